// File: doc/BRIEF.md
# Serial-Bus Validated Configuration Register Target

This block is a target on a two-wire serial bus (I2C) that owns a small configuration register, five bits wide by default. It runs from a system clock. The SCL and SDA inputs arrive already synchronised, and SDA is driven through an open-drain enable: when `sda_oe` is high the line is pulled low. The target answers one fixed 7-bit address. A read returns the stored value, padded with zeros in the upper bits. A write is screened byte by byte. Only the first byte whose upper bits are all zero is held as a candidate. A write-protect input is sampled on the SCL falling edge that closes the acknowledge of that byte. The candidate reaches the register only when a STOP arrives.

After each commit, a counter runs for a parameterised number of clock cycles. This models the programming time of a persistent cell. While the counter runs, `busy` is high and the target ignores its own address. The committed value appears on a parallel output, which downstream logic can use directly as configuration. Register bit 4 is the stand-alone output bit; bits 3 to 0 feed four selectable outputs, highest to lowest.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 1001110 (bit 0 is R/W, where 1 means read). It acknowledges by driving `sda_oe` high for the ninth clock pulse. Any other address, including the general-call address 0000000, leaves `sda_oe` low and the target silent until the next START.
- R2: After a read address, the target sends {000, register} MSB first, with a 1 on the line meaning `sda_oe` low. If the master acknowledges, the same value is sent again. A master not-acknowledge releases the bus.
- R3: A data byte is valid when bits 7:5 are zero. At the clock edge that detects STOP, a committed valid byte places its bits 4:0 on `cfg_q[4:0]`.
- R4: A data byte with any of bits 7:5 set is still acknowledged, but it is never stored.
- R5: Only the first valid data byte of a transaction can be committed. Later bytes, valid or not, are acknowledged and have no effect. This holds even when the first valid byte was blocked by write-protect.
- R6: `wp_i` is sampled at the SCL falling edge that ends the acknowledge of the first valid byte. If it is high there, STOP commits nothing. Its level at any other time does not matter.
- R7: Nothing is written when STOP arrives in the middle of a byte. A repeated START discards a pending byte.
- R8: A commit raises `busy` for exactly BUSY_CYCLES clock cycles, starting at the STOP edge. While `busy` is high, the own address is not acknowledged.
- R9: After reset, `cfg_q` is 0, `busy` is 0 and `sda_oe` is 0.
- R10: `cfg_q` changes at no clock edge other than one that detects STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line |
| wp_i | input | 1 | Write-protect, high blocks a commit |
| sda_oe | output | 1 | Open-drain data enable, high pulls SDA low |
| cfg_q | output | W | Committed register value |
| busy | output | 1 | Commit programming period in progress |

## Verification
The assertions check four things on every cycle. The register moves only on an edge that detects STOP. Any change of the register comes with `busy`. `busy` only rises on a STOP edge. No address acknowledge begins while `busy` was high. Other behaviour only the bench scenarios can show: address matching and general-call rejection, the screening of invalid bytes, the first-valid-byte rule, write-protect sampled at exactly one edge, aborted bytes and repeated STARTs that write nothing, and the exact length of the busy window. For these, the bench compares its own model of the register and busy time on every clock.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_WDAT, PH_WACK, PH_RDAT, PH_RACK, PH_SKIP
  } phase_t;

  // a data byte qualifies when nothing is set at or above the register width
  function automatic logic byte_is_valid(logic [7:0] b, int w);
    return (b >> w) == 8'd0;
  endfunction

  function automatic logic addr_hits(logic [7:0] b, logic [6:0] a);
    return b[7:1] == a;
  endfunction
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import cfgreg_pkg::*;
#(
  parameter logic [6:0] ADDR = 7'b1001110,
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_evt,
  input  logic         stop_evt,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_i,
  input  logic         busy,
  input  logic [W-1:0] cfg_q,
  output logic         sda_oe,
  output logic         ack_end,
  output logic [7:0]   rx_byte,
  output logic         addr_ack_st
);
  phase_t      st;
  logic [7:0]  shreg;
  logic [3:0]  bitcnt;
  logic        rw, mack;
  logic        full;

  assign full = (bitcnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
    end else if (start_evt) begin
      st     <= PH_ADDR;
      bitcnt <= '0;
    end else if (stop_evt) begin
      st <= PH_IDLE;
    end else begin
      case (st)
        PH_ADDR, PH_WDAT: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_i};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && full) begin
            if (st == PH_WDAT) st <= PH_WACK;
            else if (addr_hits(shreg, ADDR) && !busy) begin
              st <= PH_AACK;
              rw <= shreg[0];
            end else st <= PH_SKIP;
          end
        end
        PH_AACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            st    <= PH_RDAT;
            shreg <= {{(8-W){1'b0}}, cfg_q};
          end else st <= PH_WDAT;
        end
        PH_WACK: if (scl_fall) begin
          st     <= PH_WDAT;
          bitcnt <= '0;
        end
        PH_RDAT: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (full) st <= PH_RACK;
            else shreg <= {shreg[6:0], 1'b0};
          end
        end
        PH_RACK: begin
          if (scl_rise) mack <= ~sda_i;
          else if (scl_fall) begin
            if (mack) begin
              st     <= PH_RDAT;
              shreg  <= {{(8-W){1'b0}}, cfg_q};
              bitcnt <= '0;
            end else st <= PH_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign addr_ack_st = (st == PH_AACK);
  assign sda_oe  = addr_ack_st | (st == PH_WACK) | ((st == PH_RDAT) & ~shreg[7]);
  assign ack_end = (st == PH_WACK) & scl_fall & ~start_evt & ~stop_evt;
  assign rx_byte = shreg;
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfgreg_pkg::*;
#(
  parameter int W = 5,
  parameter int BUSY_CYCLES = 1250000,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_evt,
  input  logic         stop_evt,
  input  logic         ack_end,
  input  logic [7:0]   rx_byte,
  input  logic         wp_i,
  output logic [W-1:0] cfg_q,
  output logic         busy,
  output logic         commit
);
  logic         taken, pend;
  logic [W-1:0] pdata;
  logic [CW-1:0] cnt;

  assign commit = stop_evt & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= 1'b0;
      pend  <= 1'b0;
      pdata <= '0;
      cfg_q <= '0;
    end else if (start_evt || stop_evt) begin
      if (commit) cfg_q <= pdata;
      taken <= 1'b0;
      pend  <= 1'b0;
    end else if (ack_end && !taken && byte_is_valid(rx_byte, W)) begin
      taken <= 1'b1;
      pend  <= ~wp_i;
      pdata <= rx_byte[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (commit) cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [6:0] ADDR = 7'b1001110,
  parameter int W = 5,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic         wp_i,
  output logic         sda_oe,
  output logic [W-1:0] cfg_q,
  output logic         busy
);
  logic start_evt, stop_evt, scl_rise, scl_fall;
  logic ack_end, addr_ack_st, commit;
  logic [7:0] rx_byte;

  i2c_line_events u_ev (
    .clk, .rst_n, .scl_i, .sda_i,
    .start_evt, .stop_evt, .scl_rise, .scl_fall
  );

  i2c_byte_engine #(.ADDR(ADDR), .W(W)) u_eng (
    .clk, .rst_n, .start_evt, .stop_evt, .scl_rise, .scl_fall, .sda_i,
    .busy, .cfg_q, .sda_oe, .ack_end, .rx_byte, .addr_ack_st
  );

  cfg_commit #(.W(W), .BUSY_CYCLES(BUSY_CYCLES)) u_cmt (
    .clk, .rst_n, .start_evt, .stop_evt, .ack_end, .rx_byte, .wp_i,
    .cfg_q, .busy, .commit
  );
endmodule

// File: rtl/cfg_target_checker.sv
module cfg_target_checker #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stop_evt,
  input logic         addr_ack_st,
  input logic         busy,
  input logic [W-1:0] cfg_q
);
  assert_cfg_only_at_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(stop_evt));

  assert_cfg_change_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> busy);

  assert_busy_rise_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  assert_no_ack_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_ack_st) |-> !$past(busy));
endmodule

bind i2c_cfg_target cfg_target_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt),
  .addr_ack_st(addr_ack_st), .busy(busy), .cfg_q(cfg_q)
);

// File: tb/i2c_cfg_target_tb.sv
`timescale 1ns/1ps
module i2c_cfg_target_tb;
  localparam int BUSY = 300;
  localparam int Q = 4;
  localparam logic [7:0] AW = 8'b1001_1100;
  localparam logic [7:0] AR = 8'b1001_1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_line, sda_oe, busy;
  logic [4:0] cfg_q;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_target #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
    .sda_oe, .cfg_q, .busy
  );

  int vectors = 0, miscompares = 0;
  logic [4:0] exp_cfg = '0;
  int busy_left = 0;
  bit m_taken = 0, m_pend = 0, done = 0;
  logic [4:0] m_data = '0;
  bit monitor_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (busy_left > 0) busy_left <= busy_left - 1;

  always @(negedge clk) if (monitor_on) begin
    chk(cfg_q == exp_cfg, "R10 cfg_q per-cycle", cfg_q, exp_cfg);
    chk(busy == (busy_left > 0), "R8 busy per-cycle", busy, busy_left > 0);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) sda_m = 1'b1;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b0;
    m_taken = 0; m_pend = 0;
    wait_n(Q);
  endtask

  task automatic do_stop();
    @(negedge clk) sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); sda_m = 1'b1;
    @(posedge clk); #1;
    if (m_pend) begin
      exp_cfg = m_data;
      busy_left = BUSY;
    end
    m_taken = 0; m_pend = 0;
    wait_n(2*Q);
  endtask

  task automatic clock_bit(input logic b);
    @(negedge clk) sda_m = b;
    wait_n(Q); scl_m = 1'b1;
    wait_n(2*Q); scl_m = 1'b0;
    wait_n(Q);
  endtask

  // sends a byte, releases SDA for the ninth pulse; wp_fall is the level at the ack falling edge
  task automatic send_byte(input logic [7:0] b, input logic wp_during, input logic wp_fall,
                           input bit is_data, output bit acked);
    wp = wp_during;
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    @(negedge clk) sda_m = 1'b1;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); acked = !sda_line; wp = wp_fall;
    wait_n(Q); scl_m = 1'b0;
    if (is_data && acked && !m_taken && b[7:5] == 3'b000) begin
      m_taken = 1; m_pend = !wp_fall; m_data = b[4:0];
    end
    wait_n(2); wp = wp_during;
    wait_n(Q-2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    @(negedge clk) sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(Q); scl_m = 1'b1;
      wait_n(Q); b[i] = sda_line;
      wait_n(Q); scl_m = 1'b0;
      wait_n(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wait_n(Q); scl_m = 1'b1;
    wait_n(2*Q); scl_m = 1'b0;
    wait_n(1); sda_m = 1'b1;
    wait_n(Q);
  endtask

  task automatic write_txn(input logic [7:0] d, input logic wpd, input logic wpf);
    bit a;
    do_start();
    send_byte(AW, 1'b0, 1'b0, 0, a);
    chk(a, "R1 own write address acked", a, 1);
    send_byte(d, wpd, wpf, 1, a);
    chk(a, "R4 data byte acked", a, 1);
    do_stop();
  endtask

  task automatic read_check(input logic [4:0] expv, input string tag);
    bit a; logic [7:0] r;
    do_start();
    send_byte(AR, 1'b0, 1'b0, 0, a);
    chk(a, "R1 read address acked", a, 1);
    recv_byte(0, r);
    chk(r == {3'b000, expv}, tag, r, {3'b000, expv});
    do_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    bit a; logic [7:0] r, r2;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    // R9 reset state
    chk(cfg_q == 0, "R9 cfg_q after reset", cfg_q, 0);
    chk(busy == 0, "R9 busy after reset", busy, 0);
    chk(sda_oe == 0, "R9 sda_oe after reset", sda_oe, 0);
    monitor_on = 1;

    read_check(5'h00, "R2 read default value");

    // R3 valid write commits at STOP, R8 busy starts
    write_txn(8'h15, 1'b0, 1'b0);
    chk(cfg_q == 5'h15, "R3 committed value", cfg_q, 5'h15);
    chk(busy == 1, "R8 busy after commit", busy, 1);

    // R8 own address ignored while busy
    do_start();
    send_byte(AW, 1'b0, 1'b0, 0, a);
    chk(!a, "R8 address nacked while busy", a, 0);
    do_stop();
    wait_n(BUSY + 4);
    read_check(5'h15, "R2 read back committed value");

    // R1 foreign address and general call
    do_start();
    send_byte(8'b1001_1000, 1'b0, 1'b0, 0, a);
    chk(!a, "R1 foreign address nacked", a, 0);
    do_stop();
    do_start();
    send_byte(8'h00, 1'b0, 1'b0, 0, a);
    chk(!a, "R1 general call nacked", a, 0);
    do_stop();

    // R4/R5 invalid first, then first valid, then another valid
    do_start();
    send_byte(AW, 1'b0, 1'b0, 0, a);
    send_byte(8'h35, 1'b0, 1'b0, 1, a);
    chk(a, "R4 invalid byte acked", a, 1);
    send_byte(8'h0A, 1'b0, 1'b0, 1, a);
    send_byte(8'h1F, 1'b0, 1'b0, 1, a);
    chk(a, "R5 later byte acked", a, 1);
    do_stop();
    chk(cfg_q == 5'h0A, "R5 first valid byte kept", cfg_q, 5'h0A);
    wait_n(BUSY + 4);

    // R4 only invalid byte: nothing stored
    write_txn(8'hE1, 1'b0, 1'b0);
    chk(cfg_q == 5'h0A && !busy, "R4 invalid byte not stored", cfg_q, 5'h0A);

    // R6 protected at the edge
    write_txn(8'h1F, 1'b1, 1'b1);
    chk(cfg_q == 5'h0A, "R6 wp high blocks commit", cfg_q, 5'h0A);
    // R6 high elsewhere, low at the edge
    write_txn(8'h03, 1'b1, 1'b0);
    chk(cfg_q == 5'h03, "R6 wp low at edge commits", cfg_q, 5'h03);
    wait_n(BUSY + 4);
    // R6 low elsewhere, high at the edge
    write_txn(8'h07, 1'b0, 1'b1);
    chk(cfg_q == 5'h03, "R6 wp high only at edge blocks", cfg_q, 5'h03);

    // R5 blocked first valid byte, second valid unprotected: still nothing
    do_start();
    send_byte(AW, 1'b0, 1'b0, 0, a);
    send_byte(8'h11, 1'b0, 1'b1, 1, a);
    send_byte(8'h12, 1'b0, 1'b0, 1, a);
    do_stop();
    chk(cfg_q == 5'h03, "R5 only first valid byte is candidate", cfg_q, 5'h03);

    // R7 abort mid-byte
    do_start();
    send_byte(AW, 1'b0, 1'b0, 0, a);
    clock_bit(1'b0); clock_bit(1'b0); clock_bit(1'b0); clock_bit(1'b1);
    do_stop();
    chk(cfg_q == 5'h03 && !busy, "R7 aborted byte writes nothing", cfg_q, 5'h03);

    // R7 repeated START drops pending byte
    do_start();
    send_byte(AW, 1'b0, 1'b0, 0, a);
    send_byte(8'h19, 1'b0, 1'b0, 1, a);
    do_start();
    send_byte(AR, 1'b0, 1'b0, 0, a);
    recv_byte(0, r);
    chk(r == 8'h03, "R7 read after repeated start", r, 8'h03);
    do_stop();
    chk(cfg_q == 5'h03 && !busy, "R7 repeated start discards pending", cfg_q, 5'h03);

    // R2 master ack repeats value
    do_start();
    send_byte(AR, 1'b0, 1'b0, 0, a);
    recv_byte(1, r);
    recv_byte(0, r2);
    chk(r == 8'h03, "R2 first read byte", r, 8'h03);
    chk(r2 == 8'h03, "R2 second read byte", r2, 8'h03);
    do_stop();
    chk(sda_oe == 0, "R2 bus released after nack", sda_oe, 0);

    wait_n(10);
    finish_run();
  end
endmodule